// File: doc/BRIEF.md
# Width-Aware Memory Map Decoder

This block routes one processor-side request to one of several memory targets. Each request carries an address, an access size (byte, halfword or word), a read/write flag and write data. The top address byte picks the target: a boot ROM, two work RAMs, an I/O register file, palette RAM, video RAM, object RAM, cartridge ROM, or an 8-bit backup store. The address sent to a wide target is forced into alignment for its size. Reads of the byte-wide backup store are spread across the access width. Writes to it pick one byte lane.

The request strobe selects the target in the same cycle, and the targets answer combinationally. The router registers the formatted read data and returns it one cycle later with a valid strobe. Some writes are refused: writes to the boot ROM, byte writes to the three video memories, and writes to unmapped pages. These are dropped, and a one-cycle error pulse follows them. Cartridge writes are dropped without any error. An access to an unmapped page also raises an undefined-access pulse, and a read there returns zero.

A two-state response machine sequences the output. In ST_IDLE no response is pending. A read request moves it to ST_RDATA (transition T_RD_ISSUE). ST_RDATA is held for one cycle and drives the response. From there, another read stays in ST_RDATA (T_RD_CHAIN), and anything else returns to ST_IDLE (T_DRAIN). In ST_IDLE without a read, the machine stays put (T_HOLD).

Top module: `memmap_router`

## Requirements
- R1: For an accepted access, exactly one select is driven, and only while the request is valid. The mapping is: page 0x00 drives tgt_sel bit 0, 0x02 bit 1, 0x03 bit 2, 0x04 bit 3, 0x05 bit 4, 0x06 bit 5, 0x07 bit 6, pages 0x08 to 0x0D bit 7, and pages 0x0E and 0x0F drive bkp_sel. The page is address bits [31:24].
- R2: The size code is 0 for byte, 1 for halfword and 2 for word. tgt_addr_o equals the request address with bits [1:0] cleared for a word, bit 0 cleared for a halfword, and nothing cleared for a byte. bkp_addr_o is always the unaligned request address.
- R3: A read produces rsp_valid_o high in the cycle after the request. Its data is the selected target's read data, masked to the low 8 bits for a byte and to the low 16 bits for a halfword.
- R4: A backup read returns its byte b as {24'b0,b} for a byte, {16'b0,b,b} for a halfword and {b,b,b,b} for a word.
- R5: A backup write stores one byte. For a word it is write-data byte lane addr[1:0]. For a halfword it is lane addr[0]. For a byte it is lane 0.
- R6: Writes to pages 0x08 to 0x0D drive no select and raise neither err_o nor undef_o.
- R7: Byte writes to pages 0x05 to 0x07 drive no select and pulse err_o in the next cycle. Halfword and word writes there are passed through with tgt_we_o high.
- R8: Writes to page 0x00 drive no select and pulse err_o in the next cycle.
- R9: An access to a page not listed in R1 drives no select. It pulses err_o and undef_o in the next cycle. A read there returns zero with rsp_valid_o.
- R10: While reset is held, rsp_valid_o, err_o and undef_o are low.
- R11: A write request, or an idle cycle, is followed by rsp_valid_o low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| req_valid_i | input | 1 | Request strobe |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_size_i | input | 2 | 0 byte, 1 halfword, 2 word |
| req_addr_i | input | 32 | Request address |
| req_wdata_i | input | 32 | Write data |
| rsp_valid_o | output | 1 | Read data valid, one cycle after a read |
| rsp_rdata_o | output | 32 | Read data |
| err_o | output | 1 | Pulse after a refused or unmapped access |
| undef_o | output | 1 | Pulse after an unmapped access |
| tgt_sel_o | output | 8 | One-hot select of the wide targets |
| tgt_we_o | output | 1 | Write enable for the wide targets |
| tgt_size_o | output | 2 | Access size for the wide targets |
| tgt_addr_o | output | 32 | Aligned target address |
| tgt_wdata_o | output | 32 | Write data for the wide targets |
| tgt_rdata_i | input | 256 | Read data, 32 bits per wide target, target 0 lowest |
| bkp_sel_o | output | 1 | Backup store select |
| bkp_we_o | output | 1 | Backup store write enable |
| bkp_addr_o | output | 32 | Unaligned backup address |
| bkp_wdata_o | output | 8 | Backup write byte |
| bkp_rdata_i | input | 8 | Backup read byte |

## Verification
The assertions assume that req_size_i never carries the unused code 3. They also assume that the request inputs are low or stable whenever reset is asserted, so that no $past term sees a request from the reset cycles. The stimulus keeps to this. It drives only the three legal size codes, holds req_valid_i low through reset, and sweeps every page from 0x00 to 0x11 plus 0x80 and 0xFF, every low-address offset, every size and both directions. Read data comes from stubs whose value is derived from the target index and the aligned address, so both a misrouted read and a misaligned read show up.

// File: rtl/memmap_pkg.sv
package memmap_pkg;

    localparam int unsigned NUM_TGT = 8;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSVD = 2'd3
    } size_e;

    // Values 0..7 equal the bit index of the wide-target select.
    typedef enum logic [3:0] {
        RG_BOOT  = 4'd0,
        RG_WRAM0 = 4'd1,
        RG_WRAM1 = 4'd2,
        RG_IO    = 4'd3,
        RG_PAL   = 4'd4,
        RG_VRAM  = 4'd5,
        RG_OAM   = 4'd6,
        RG_CART  = 4'd7,
        RG_BKP   = 4'd8,
        RG_NONE  = 4'd9
    } region_e;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_RDATA = 1'b1
    } rsp_state_e;

endpackage

// File: rtl/memmap_decode.sv
module memmap_decode
    import memmap_pkg::*;
#(
    parameter int unsigned PAGE_W = 8
) (
    input  logic [PAGE_W-1:0] page_i,
    output region_e           region_o
);

    always_comb begin
        unique case (page_i) inside
            PAGE_W'(8'h00):                 region_o = RG_BOOT;
            PAGE_W'(8'h02):                 region_o = RG_WRAM0;
            PAGE_W'(8'h03):                 region_o = RG_WRAM1;
            PAGE_W'(8'h04):                 region_o = RG_IO;
            PAGE_W'(8'h05):                 region_o = RG_PAL;
            PAGE_W'(8'h06):                 region_o = RG_VRAM;
            PAGE_W'(8'h07):                 region_o = RG_OAM;
            [PAGE_W'(8'h08):PAGE_W'(8'h0D)]: region_o = RG_CART;
            [PAGE_W'(8'h0E):PAGE_W'(8'h0F)]: region_o = RG_BKP;
            default:                        region_o = RG_NONE;
        endcase
    end

endmodule

// File: rtl/memmap_policy.sv
module memmap_policy
    import memmap_pkg::*;
(
    input  logic               valid_i,
    input  logic               write_i,
    input  size_e              size_i,
    input  region_e            region_i,
    output logic [NUM_TGT-1:0] tgt_sel_o,
    output logic               bkp_sel_o,
    output logic               err_o,
    output logic               undef_o
);

    logic accept;
    logic refuse;

    always_comb begin
        accept = 1'b0;
        refuse = 1'b0;
        if (!write_i) begin
            accept = (region_i != RG_NONE);
            refuse = (region_i == RG_NONE);
        end else begin
            unique case (region_i)
                RG_WRAM0, RG_WRAM1, RG_IO, RG_BKP: accept = 1'b1;
                RG_PAL, RG_VRAM, RG_OAM: begin
                    accept = (size_i != SZ_BYTE);
                    refuse = (size_i == SZ_BYTE);
                end
                RG_CART: accept = 1'b0;
                RG_BOOT, RG_NONE: refuse = 1'b1;
                default: refuse = 1'b1;
            endcase
        end
    end

    for (genvar g = 0; g < NUM_TGT; g++) begin : g_sel
        assign tgt_sel_o[g] = valid_i && accept && (region_i == region_e'(g));
    end

    assign bkp_sel_o = valid_i && accept && (region_i == RG_BKP);
    assign err_o     = valid_i && refuse;
    assign undef_o   = valid_i && (region_i == RG_NONE);

endmodule

// File: rtl/memmap_lane.sv
module memmap_lane
    import memmap_pkg::*;
#(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned DATA_W = 32
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  size_e             size_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [ADDR_W-1:0] tgt_addr_o,
    output logic [7:0]        bkp_wbyte_o
);

    localparam int unsigned LANES = DATA_W / 8;
    localparam int unsigned LSB_W = $clog2(LANES);

    logic [LSB_W-1:0] lane;

    always_comb begin
        unique case (size_i)
            SZ_BYTE: begin
                tgt_addr_o = addr_i;
                lane       = '0;
            end
            SZ_HALF: begin
                tgt_addr_o = {addr_i[ADDR_W-1:1], 1'b0};
                lane       = LSB_W'(addr_i[0]);
            end
            default: begin
                tgt_addr_o = {addr_i[ADDR_W-1:LSB_W], {LSB_W{1'b0}}};
                lane       = addr_i[LSB_W-1:0];
            end
        endcase
    end

    assign bkp_wbyte_o = wdata_i[{lane, 3'b000} +: 8];

endmodule

// File: rtl/memmap_resp.sv
module memmap_resp
    import memmap_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  logic                      clk_i,
    input  logic                      rst_i,
    input  logic                      rd_fire_i,
    input  logic                      err_i,
    input  logic                      undef_i,
    input  region_e                   region_i,
    input  size_e                     size_i,
    input  logic [NUM_TGT*DATA_W-1:0] tgt_rdata_i,
    input  logic [7:0]                bkp_rdata_i,
    output logic                      rsp_valid_o,
    output logic [DATA_W-1:0]         rsp_rdata_o,
    output logic                      err_o,
    output logic                      undef_o
);

    localparam int unsigned LANES = DATA_W / 8;

    rsp_state_e        state_q;
    rsp_state_e        state_d;
    logic [DATA_W-1:0] picked;
    logic [DATA_W-1:0] shaped;
    logic [DATA_W-1:0] rdata_q;
    logic              err_q;
    logic              undef_q;

    always_comb begin
        picked = '0;
        for (int i = 0; i < NUM_TGT; i++) begin
            if (region_i == region_e'(i[3:0])) begin
                picked = tgt_rdata_i[i*DATA_W +: DATA_W];
            end
        end
    end

    always_comb begin
        if (region_i == RG_NONE) begin
            shaped = '0;
        end else if (region_i == RG_BKP) begin
            unique case (size_i)
                SZ_BYTE: shaped = DATA_W'(bkp_rdata_i);
                SZ_HALF: shaped = DATA_W'({bkp_rdata_i, bkp_rdata_i});
                default: shaped = {LANES{bkp_rdata_i}};
            endcase
        end else begin
            unique case (size_i)
                SZ_BYTE: shaped = picked & DATA_W'(8'hFF);
                SZ_HALF: shaped = picked & DATA_W'(16'hFFFF);
                default: shaped = picked;
            endcase
        end
    end

    // Next-state logic: T_RD_ISSUE, T_RD_CHAIN, T_DRAIN, T_HOLD.
    always_comb begin
        unique case (state_q)
            ST_IDLE:  state_d = rd_fire_i ? ST_RDATA : ST_IDLE;
            ST_RDATA: state_d = rd_fire_i ? ST_RDATA : ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            rdata_q <= '0;
            err_q   <= 1'b0;
            undef_q <= 1'b0;
        end else begin
            if (rd_fire_i) begin
                rdata_q <= shaped;
            end
            err_q   <= err_i;
            undef_q <= undef_i;
        end
    end

    assign rsp_valid_o = (state_q == ST_RDATA);
    assign rsp_rdata_o = rdata_q;
    assign err_o       = err_q;
    assign undef_o     = undef_q;

endmodule

// File: rtl/memmap_router.sv
module memmap_router
    import memmap_pkg::*;
#(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned PAGE_W = 8
) (
    input  logic                      clk_i,
    input  logic                      rst_i,
    input  logic                      req_valid_i,
    input  logic                      req_write_i,
    input  logic [1:0]                req_size_i,
    input  logic [ADDR_W-1:0]         req_addr_i,
    input  logic [DATA_W-1:0]         req_wdata_i,
    output logic                      rsp_valid_o,
    output logic [DATA_W-1:0]         rsp_rdata_o,
    output logic                      err_o,
    output logic                      undef_o,
    output logic [NUM_TGT-1:0]        tgt_sel_o,
    output logic                      tgt_we_o,
    output logic [1:0]                tgt_size_o,
    output logic [ADDR_W-1:0]         tgt_addr_o,
    output logic [DATA_W-1:0]         tgt_wdata_o,
    input  logic [NUM_TGT*DATA_W-1:0] tgt_rdata_i,
    output logic                      bkp_sel_o,
    output logic                      bkp_we_o,
    output logic [ADDR_W-1:0]         bkp_addr_o,
    output logic [7:0]                bkp_wdata_o,
    input  logic [7:0]                bkp_rdata_i
);

    size_e   size;
    region_e region;
    logic    err_now;
    logic    undef_now;

    assign size = size_e'(req_size_i);

    memmap_decode #(.PAGE_W(PAGE_W)) u_decode (
        .page_i   (req_addr_i[ADDR_W-1 -: PAGE_W]),
        .region_o (region)
    );

    memmap_policy u_policy (
        .valid_i   (req_valid_i),
        .write_i   (req_write_i),
        .size_i    (size),
        .region_i  (region),
        .tgt_sel_o (tgt_sel_o),
        .bkp_sel_o (bkp_sel_o),
        .err_o     (err_now),
        .undef_o   (undef_now)
    );

    memmap_lane #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_lane (
        .addr_i      (req_addr_i),
        .size_i      (size),
        .wdata_i     (req_wdata_i),
        .tgt_addr_o  (tgt_addr_o),
        .bkp_wbyte_o (bkp_wdata_o)
    );

    memmap_resp #(.DATA_W(DATA_W)) u_resp (
        .clk_i       (clk_i),
        .rst_i       (rst_i),
        .rd_fire_i   (req_valid_i && !req_write_i),
        .err_i       (err_now),
        .undef_i     (undef_now),
        .region_i    (region),
        .size_i      (size),
        .tgt_rdata_i (tgt_rdata_i),
        .bkp_rdata_i (bkp_rdata_i),
        .rsp_valid_o (rsp_valid_o),
        .rsp_rdata_o (rsp_rdata_o),
        .err_o       (err_o),
        .undef_o     (undef_o)
    );

    assign tgt_we_o    = req_write_i;
    assign tgt_size_o  = req_size_i;
    assign tgt_wdata_o = req_wdata_i;
    assign bkp_we_o    = req_write_i;
    assign bkp_addr_o  = req_addr_i;

endmodule

// File: rtl/memmap_router_chk.sv
module memmap_router_chk (
    input logic         clk_i,
    input logic         rst_i,
    input logic         req_valid_i,
    input logic         req_write_i,
    input logic [1:0]   req_size_i,
    input logic [31:0]  req_addr_i,
    input logic [31:0]  req_wdata_i,
    input logic         rsp_valid_o,
    input logic [31:0]  rsp_rdata_o,
    input logic         err_o,
    input logic         undef_o,
    input logic [7:0]   tgt_sel_o,
    input logic [31:0]  tgt_addr_o,
    input logic         bkp_sel_o,
    input logic         bkp_we_o,
    input logic [7:0]   bkp_wdata_o,
    input logic [7:0]   bkp_rdata_i
);

    logic [7:0] page;
    logic       cart_wr;
    logic       video_byte_wr;

    assign page          = req_addr_i[31:24];
    assign cart_wr       = req_valid_i && req_write_i && page >= 8'h08 && page <= 8'h0D;
    assign video_byte_wr = req_valid_i && req_write_i && req_size_i == 2'd0
                           && page >= 8'h05 && page <= 8'h07;

    a_r1_single_select: assert property (@(posedge clk_i) disable iff (rst_i)
        $onehot0({bkp_sel_o, tgt_sel_o}));

    a_r1_idle_no_select: assert property (@(posedge clk_i) disable iff (rst_i)
        !req_valid_i |-> (tgt_sel_o == 8'h00 && !bkp_sel_o));

    a_r2_word_aligned: assert property (@(posedge clk_i) disable iff (rst_i)
        req_size_i == 2'd2 |-> tgt_addr_o[1:0] == 2'b00);

    a_r3_read_answered: assert property (@(posedge clk_i) disable iff (rst_i)
        (req_valid_i && !req_write_i) |=> rsp_valid_o);

    a_r4_word_replicated: assert property (@(posedge clk_i) disable iff (rst_i)
        (bkp_sel_o && !req_write_i && req_size_i == 2'd2)
        |=> rsp_rdata_o == {4{$past(bkp_rdata_i)}});

    a_r5_word_lane: assert property (@(posedge clk_i) disable iff (rst_i)
        (bkp_sel_o && bkp_we_o && req_size_i == 2'd2)
        |-> bkp_wdata_o == req_wdata_i[{req_addr_i[1:0], 3'b000} +: 8]);

    a_r6_cart_dropped: assert property (@(posedge clk_i) disable iff (rst_i)
        cart_wr |-> (tgt_sel_o == 8'h00 && !bkp_sel_o));

    a_r6_cart_silent: assert property (@(posedge clk_i) disable iff (rst_i)
        cart_wr |=> (!err_o && !undef_o));

    a_r7_video_byte_flagged: assert property (@(posedge clk_i) disable iff (rst_i)
        video_byte_wr |=> err_o);

    a_r9_undef_reads_zero: assert property (@(posedge clk_i) disable iff (rst_i)
        (rsp_valid_o && undef_o) |-> rsp_rdata_o == 32'h0);

    a_r9_undef_implies_err: assert property (@(posedge clk_i) disable iff (rst_i)
        undef_o |-> err_o);

    a_r11_no_spurious_rsp: assert property (@(posedge clk_i) disable iff (rst_i)
        !(req_valid_i && !req_write_i) |=> !rsp_valid_o);

endmodule

bind memmap_router memmap_router_chk u_chk (.*);

// File: tb/memmap_router_tb.sv
module memmap_router_tb;

    localparam int NT = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic          req_write = 1'b0;
    logic [1:0]    req_size = 2'd0;
    logic [31:0]   req_addr = '0;
    logic [31:0]   req_wdata = '0;
    logic          rsp_valid;
    logic [31:0]   rsp_rdata;
    logic          err;
    logic          undef;
    logic [NT-1:0] tgt_sel;
    logic          tgt_we;
    logic [1:0]    tgt_size;
    logic [31:0]   tgt_addr;
    logic [31:0]   tgt_wdata;
    logic [NT*32-1:0] tgt_rdata;
    logic          bkp_sel;
    logic          bkp_we;
    logic [31:0]   bkp_addr;
    logic [7:0]    bkp_wdata;
    logic [7:0]    bkp_rdata;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    // Read stubs: value identifies the target and the aligned address.
    for (genvar g = 0; g < NT; g++) begin : g_stub
        assign tgt_rdata[g*32 +: 32] = {4'hA, 4'(g), tgt_addr[23:0]};
    end
    assign bkp_rdata = bkp_addr[7:0] ^ 8'h5A;

    memmap_router u_dut (
        .clk_i(clk), .rst_i(rst),
        .req_valid_i(req_valid), .req_write_i(req_write), .req_size_i(req_size),
        .req_addr_i(req_addr), .req_wdata_i(req_wdata),
        .rsp_valid_o(rsp_valid), .rsp_rdata_o(rsp_rdata), .err_o(err), .undef_o(undef),
        .tgt_sel_o(tgt_sel), .tgt_we_o(tgt_we), .tgt_size_o(tgt_size),
        .tgt_addr_o(tgt_addr), .tgt_wdata_o(tgt_wdata), .tgt_rdata_i(tgt_rdata),
        .bkp_sel_o(bkp_sel), .bkp_we_o(bkp_we), .bkp_addr_o(bkp_addr),
        .bkp_wdata_o(bkp_wdata), .bkp_rdata_i(bkp_rdata)
    );

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    function automatic int region_of(input logic [7:0] p);
        if (p == 8'h00) return 0;
        if (p == 8'h02) return 1;
        if (p == 8'h03) return 2;
        if (p == 8'h04) return 3;
        if (p == 8'h05) return 4;
        if (p == 8'h06) return 5;
        if (p == 8'h07) return 6;
        if (p >= 8'h08 && p <= 8'h0D) return 7;
        if (p == 8'h0E || p == 8'h0F) return 8;
        return -1;
    endfunction

    task automatic run_vec(input logic [7:0] page, input logic [1:0] sz,
                           input logic [1:0] lo, input logic wr);
        logic [31:0] addr, wdata, mask, al, exp_rd;
        logic [7:0]  b;
        int rg, lane;
        logic video, accept, exp_err, exp_undef, exp_bkp;
        logic [NT-1:0] exp_sel;
        string tag;
        addr  = {page, 8'h12, 8'h34, 6'b101100, lo};
        wdata = 32'h44332211 ^ {4{page}};
        rg    = region_of(page);
        video = (rg >= 4 && rg <= 6);
        mask  = (sz == 2'd0) ? 32'h0000_00FF : (sz == 2'd1) ? 32'h0000_FFFF : 32'hFFFF_FFFF;
        al    = (sz == 2'd2) ? (addr & ~32'h3) : (sz == 2'd1) ? (addr & ~32'h1) : addr;
        if (!wr) accept = (rg >= 0);
        else     accept = (rg >= 1 && rg <= 3) || rg == 8 || (video && sz != 2'd0);
        exp_err   = wr ? (rg == 0 || rg == -1 || (video && sz == 2'd0)) : (rg == -1);
        exp_undef = (rg == -1);
        exp_sel   = (accept && rg >= 0 && rg <= 7) ? NT'(1 << rg) : '0;
        exp_bkp   = accept && rg == 8;
        if (rg == -1)                         tag = "R9";
        else if (wr && rg == 7)               tag = "R6";
        else if (wr && video)                 tag = "R7";
        else if (wr && rg == 0)               tag = "R8";
        else                                  tag = "R1";

        req_valid = 1'b1; req_write = wr; req_size = sz;
        req_addr = addr;  req_wdata = wdata;
        #1;
        chk(tag, "tgt_sel", 32'(tgt_sel), 32'(exp_sel));
        chk(tag, "bkp_sel", 32'(bkp_sel), 32'(exp_bkp));
        if (exp_sel != '0) begin
            chk("R2", "tgt_addr", tgt_addr, al);
            if (wr) begin
                chk("R7", "tgt_we", 32'(tgt_we), 32'd1);
                chk("R7", "tgt_wdata", tgt_wdata, wdata);
            end
        end
        if (exp_bkp) begin
            chk("R2", "bkp_addr", bkp_addr, addr);
            if (wr) begin
                lane = (sz == 2'd2) ? int'(lo) : (sz == 2'd1) ? int'(lo[0]) : 0;
                chk("R5", "bkp_wdata", 32'(bkp_wdata), 32'((wdata >> (8*lane)) & 32'hFF));
            end
        end
        @(negedge clk);
        req_valid = 1'b0;
        chk(wr ? "R11" : "R3", "rsp_valid", 32'(rsp_valid), 32'(!wr));
        chk(tag, "err", 32'(err), 32'(exp_err));
        chk(tag, "undef", 32'(undef), 32'(exp_undef));
        if (!wr) begin
            if (rg == -1) exp_rd = 32'h0;
            else if (rg == 8) begin
                b = addr[7:0] ^ 8'h5A;
                exp_rd = (sz == 2'd0) ? {24'h0, b} : (sz == 2'd1) ? {16'h0, b, b} : {4{b}};
            end else exp_rd = {4'hA, 4'(rg), al[23:0]} & mask;
            chk((rg == 8) ? "R4" : (rg == -1) ? "R9" : "R3", "rsp_rdata", rsp_rdata, exp_rd);
        end
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R10", "rsp_valid in reset", 32'(rsp_valid), 32'd0);
        chk("R10", "err in reset", 32'(err), 32'd0);
        chk("R10", "undef in reset", 32'(undef), 32'd0);
        rst = 1'b0;
        @(negedge clk);

        for (int p = 0; p < 20; p++) begin
            for (int s = 0; s < 3; s++) begin
                for (int l = 0; l < 4; l++) begin
                    for (int w = 0; w < 2; w++) begin
                        run_vec((p < 18) ? 8'(p) : (p == 18) ? 8'h80 : 8'hFF,
                                2'(s), 2'(l), w[0]);
                    end
                end
            end
        end

        // Back-to-back reads: ST_RDATA held across the chain (R3), then a drain (R11).
        req_valid = 1'b1; req_write = 1'b0; req_size = 2'd2;
        req_addr = 32'h0200_0104;
        @(negedge clk);
        chk("R3", "chain rsp_valid 1", 32'(rsp_valid), 32'd1);
        chk("R3", "chain rdata 1", rsp_rdata, 32'hA100_0104);
        req_addr = 32'h0E00_0033; req_size = 2'd1;
        @(negedge clk);
        chk("R3", "chain rsp_valid 2", 32'(rsp_valid), 32'd1);
        chk("R4", "chain rdata 2", rsp_rdata, {16'h0, 8'h69, 8'h69});
        req_valid = 1'b0;
        @(negedge clk);
        chk("R11", "drain rsp_valid", 32'(rsp_valid), 32'd0);

        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #200000;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule